// File: doc/BRIEF.md
# Load Multiple Word Sequencer

This block runs a load-multiple-word operation for a processor's load/store path. Once started with a first target register index, a base register index, a starting effective address and the current endianness mode, it fetches consecutive 32-bit words from memory. It writes each word into the general-purpose registers from the first target index up to the last register, 31. Every word goes into the low half of a 64-bit register, and the high half is cleared.

Before it issues any memory read, the sequencer screens the operation. Little-endian execution is refused with an alignment-error pulse. A base register that lies inside the range being loaded is refused with an invalid-form pulse, and a base index of zero always counts as lying inside that range. Memory traffic uses a simple handshake: a one-cycle request carrying an address, then a valid strobe carrying the data. Only one read is in flight at a time. Address computation, the register file and the memory itself sit outside the block.

Top module: `lmw_seq`

## Requirements
- R1: An accepted operation with first index T writes exactly 32-T registers, indices T, T+1, ..., 31 in that order, one write per returned word.
- R2: Each register write carries the returned 32-bit word in data bits 31:0 and zeros in bits 63:32. No sign extension takes place, even when word bit 31 is 1.
- R3: The first memory request address equals the starting effective address. Each following request address is the previous one plus 4 (64-bit wrap-around), and the write index rises by 1 per word.
- R4: When the endianness bit is 0 (big-endian) and the base index is 0 or greater than or equal to the first index, invalid-form is pulsed for one cycle. It appears two cycles after the start cycle. No memory request or register write is made.
- R5: When the endianness bit is 1 (little-endian), alignment-error is pulsed for one cycle with the same timing as R4, and no request or write is made. This error takes priority: invalid-form stays low even if the base index also overlaps.
- R6: A memory request lasts one cycle, and no further request is raised until read data is returned. The next request appears in the cycle after the valid cycle. A valid strobe while no read is outstanding causes no register write.
- R7: Done is high for exactly one cycle, the cycle after the write of register 31. The block is then idle and accepts a new start in the following cycle.
- R8: Start is ignored while an operation is in progress. Its index and address inputs do not alter the running transfer.
- R9: After reset, request, write enable, done, invalid-form and alignment-error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| first_idx_i | input | 5 | First target register index |
| base_idx_i | input | 5 | Base register index used for the overlap check |
| ea_i | input | 64 | Starting effective address |
| le_mode_i | input | 1 | 1 = little-endian mode |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | 64 | Read address, valid with the request |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 32 | Read data word |
| rf_we_o | output | 1 | Register-file write enable |
| rf_idx_o | output | 5 | Register-file write index |
| rf_data_o | output | 64 | Register-file write data |
| done_o | output | 1 | One-cycle completion pulse |
| inval_o | output | 1 | One-cycle invalid-form pulse |
| align_o | output | 1 | One-cycle alignment-error pulse |

## Verification
A corrupted index or address cursor shows up at the ports within one word. The very next request carries a wrong address, or the write index skips, and the write count to register 31 comes out different from 32 minus the first index. A controller stuck in or skipping a state shows up as a missing or doubled request pulse, a done pulse that does not follow the last write by exactly one cycle, or an error pulse out of its two-cycle slot. A faulty latch of the operation fields during a run shows up as writes past register 31 or a transfer redirected by a start that should have been ignored.

// File: rtl/lmw_pkg.sv
package lmw_pkg;

    localparam int DEF_NUM_REGS = 32;
    localparam int DEF_XLEN     = 64;
    localparam int DEF_WORD_W   = 32;
    localparam int DEF_ADDR_W   = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } lmw_state_e;

    typedef enum logic [1:0] {
        VERDICT_OK,
        VERDICT_ALIGN,
        VERDICT_INVALID
    } lmw_verdict_e;

endpackage

// File: rtl/lmw_guard.sv
module lmw_guard
    import lmw_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] first_idx_i,
    input  logic [IDX_W-1:0] base_idx_i,
    input  logic             le_mode_i,
    output lmw_verdict_e     verdict_o
);

    logic overlap;

    always_comb begin
        overlap = (base_idx_i == '0) || (base_idx_i >= first_idx_i);
        if (le_mode_i)
            verdict_o = VERDICT_ALIGN;
        else if (overlap)
            verdict_o = VERDICT_INVALID;
        else
            verdict_o = VERDICT_OK;
    end

endmodule

// File: rtl/lmw_cursor.sv
module lmw_cursor #(
    parameter int IDX_W    = 5,
    parameter int ADDR_W   = 64,
    parameter int STRIDE   = 4,
    parameter int LAST_IDX = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [IDX_W-1:0]  first_idx_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic              step_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              at_last_o
);

    localparam logic [IDX_W-1:0]  LAST_V   = IDX_W'(LAST_IDX);
    localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_o  <= '0;
            addr_o <= '0;
        end else if (load_i) begin
            idx_o  <= first_idx_i;
            addr_o <= ea_i;
        end else if (step_i) begin
            idx_o  <= idx_o + IDX_W'(1);
            addr_o <= addr_o + STRIDE_V;
        end
    end

    assign at_last_o = (idx_o == LAST_V);

    AST_NO_STEP_PAST_LAST: assert property (@(posedge clk) disable iff (rst)
        step_i |-> !at_last_o); // R1

endmodule

// File: rtl/lmw_ctrl.sv
module lmw_ctrl
    import lmw_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  lmw_verdict_e verdict_i,
    input  logic         mem_valid_i,
    input  logic         at_last_i,
    output logic         load_o,
    output logic         step_o,
    output logic         mem_req_o,
    output logic         rf_we_o,
    output logic         done_o,
    output logic         inval_o,
    output logic         align_o
);

    lmw_state_e state_q, state_d;
    logic       inval_q, align_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CHECK;
            ST_CHECK: state_d = (verdict_i == VERDICT_OK) ? ST_REQ : ST_IDLE;
            ST_REQ:   state_d = ST_WAIT;
            ST_WAIT:  if (mem_valid_i) state_d = at_last_i ? ST_DONE : ST_REQ;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            inval_q <= 1'b0;
            align_q <= 1'b0;
        end else begin
            state_q <= state_d;
            inval_q <= (state_q == ST_CHECK) && (verdict_i == VERDICT_INVALID);
            align_q <= (state_q == ST_CHECK) && (verdict_i == VERDICT_ALIGN);
        end
    end

    assign load_o    = (state_q == ST_IDLE) && start_i;
    assign mem_req_o = (state_q == ST_REQ);
    assign rf_we_o   = (state_q == ST_WAIT) && mem_valid_i;
    assign step_o    = rf_we_o && !at_last_i;
    assign done_o    = (state_q == ST_DONE);
    assign inval_o   = inval_q;
    assign align_o   = align_q;

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(inval_o && align_o)); // R5

    AST_CHECK_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK) |-> ($past(state_q) == ST_IDLE)); // R8

endmodule

// File: rtl/lmw_seq.sv
module lmw_seq
    import lmw_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int XLEN     = DEF_XLEN,
    parameter int WORD_W   = DEF_WORD_W,
    parameter int ADDR_W   = DEF_ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic [$clog2(NUM_REGS)-1:0] first_idx_i,
    input  logic [$clog2(NUM_REGS)-1:0] base_idx_i,
    input  logic [ADDR_W-1:0]           ea_i,
    input  logic                        le_mode_i,
    output logic                        mem_req_o,
    output logic [ADDR_W-1:0]           mem_addr_o,
    input  logic                        mem_valid_i,
    input  logic [WORD_W-1:0]           mem_data_i,
    output logic                        rf_we_o,
    output logic [$clog2(NUM_REGS)-1:0] rf_idx_o,
    output logic [XLEN-1:0]             rf_data_o,
    output logic                        done_o,
    output logic                        inval_o,
    output logic                        align_o
);

    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int STRIDE   = WORD_W / 8;
    localparam int LAST_IDX = NUM_REGS - 1;

    logic [IDX_W-1:0] first_q, base_q;
    logic             le_q;
    logic             load, step, at_last;
    lmw_verdict_e     verdict;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            base_q  <= '0;
            le_q    <= 1'b0;
        end else if (load) begin
            first_q <= first_idx_i;
            base_q  <= base_idx_i;
            le_q    <= le_mode_i;
        end
    end

    lmw_guard #(.IDX_W(IDX_W)) u_guard (
        .first_idx_i (first_q),
        .base_idx_i  (base_q),
        .le_mode_i   (le_q),
        .verdict_o   (verdict)
    );

    lmw_cursor #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .STRIDE(STRIDE), .LAST_IDX(LAST_IDX)
    ) u_cursor (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .first_idx_i (first_idx_i),
        .ea_i        (ea_i),
        .step_i      (step),
        .idx_o       (rf_idx_o),
        .addr_o      (mem_addr_o),
        .at_last_o   (at_last)
    );

    lmw_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .verdict_i   (verdict),
        .mem_valid_i (mem_valid_i),
        .at_last_i   (at_last),
        .load_o      (load),
        .step_o      (step),
        .mem_req_o   (mem_req_o),
        .rf_we_o     (rf_we_o),
        .done_o      (done_o),
        .inval_o     (inval_o),
        .align_o     (align_o)
    );

    assign rf_data_o = {{(XLEN-WORD_W){1'b0}}, mem_data_i};

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o && rf_idx_o != IDX_W'(LAST_IDX)) |=>
        (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(STRIDE)
                   && rf_idx_o == $past(rf_idx_o) + IDX_W'(1))); // R3

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o && rf_idx_o == IDX_W'(LAST_IDX)) |=> done_o); // R7

    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (inval_o || align_o) |-> !$past(mem_req_o)); // R4

endmodule

// File: tb/lmw_seq_tb.sv
module lmw_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [4:0]  first_idx_i, base_idx_i;
    logic [63:0] ea_i;
    logic        le_mode_i;
    logic        mem_req_o;
    logic [63:0] mem_addr_o;
    logic        mem_valid_i;
    logic [31:0] mem_data_i;
    logic        rf_we_o;
    logic [4:0]  rf_idx_o;
    logic [63:0] rf_data_o;
    logic        done_o, inval_o, align_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    lmw_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .first_idx_i(first_idx_i),
        .base_idx_i(base_idx_i), .ea_i(ea_i), .le_mode_i(le_mode_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i),
        .mem_data_i(mem_data_i), .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o),
        .rf_data_o(rf_data_o), .done_o(done_o), .inval_o(inval_o), .align_o(align_o)
    );

    typedef struct packed {
        logic [4:0]  rt;
        logic [4:0]  ra;
        logic [63:0] ea;
        logic        le;
        logic [3:0]  lat;
        logic        poke;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd29, 5'd3,  64'h0000_0000_0000_1000, 1'b0, 4'd1, 1'b0},
        '{5'd31, 5'd30, 64'h0000_0000_FFFF_FFFC, 1'b0, 4'd2, 1'b1},
        '{5'd20, 5'd19, 64'h8000_0000_0000_0010, 1'b0, 4'd3, 1'b1},
        '{5'd5,  5'd5,  64'h0000_0000_0000_2000, 1'b0, 4'd1, 1'b0},
        '{5'd10, 5'd0,  64'h0000_0000_0000_3000, 1'b0, 4'd1, 1'b0},
        '{5'd10, 5'd31, 64'h0000_0000_0000_4000, 1'b0, 4'd1, 1'b0},
        '{5'd28, 5'd2,  64'h0000_0000_0000_5000, 1'b1, 4'd1, 1'b0},
        '{5'd10, 5'd0,  64'h0000_0000_0000_6000, 1'b1, 4'd1, 1'b0},
        '{5'd2,  5'd1,  64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 4'd1, 1'b0},
        '{5'd31, 5'd0,  64'h0000_0000_0000_7000, 1'b0, 4'd1, 1'b0}
    };

    function automatic logic [31:0] mdata(input logic [63:0] a);
        return a[31:0] ^ 32'hC0DE_F00D ^ {a[63:48], 16'h0000};
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input vec_t v);
        logic exp_align, exp_inv;
        int   writes;
        logic [63:0] exp_addr;
        logic [4:0]  exp_idx;
        logic        finished;
        exp_align = v.le;
        exp_inv   = !v.le && (v.ra == 5'd0 || v.ra >= v.rt);
        writes    = 0;
        exp_addr  = v.ea;
        exp_idx   = v.rt;
        finished  = 1'b0;
        first_idx_i = v.rt; base_idx_i = v.ra; ea_i = v.ea; le_mode_i = v.le;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!mem_req_o, "R6", "no request during check cycle", {63'd0, mem_req_o}, 64'd0);
        @(negedge clk);
        chk(inval_o == exp_inv, "R4", "invalid-form pulse", {63'd0, inval_o}, {63'd0, exp_inv});
        chk(align_o == exp_align, "R5", "alignment-error pulse", {63'd0, align_o}, {63'd0, exp_align});
        if (exp_inv || exp_align) begin
            chk(!mem_req_o && !rf_we_o, "R4", "no traffic on error",
                {62'd0, mem_req_o, rf_we_o}, 64'd0);
            @(negedge clk);
            chk(!inval_o && !align_o && !mem_req_o, "R5", "error is one cycle, stays idle",
                {61'd0, inval_o, align_o, mem_req_o}, 64'd0);
            return;
        end
        while (!finished) begin
            if (mem_req_o) begin
                chk(mem_addr_o == exp_addr, "R3", "request address", mem_addr_o, exp_addr);
                for (int k = 1; k <= int'(v.lat); k++) begin
                    @(negedge clk);
                    if (v.poke) begin
                        start_i = 1'b1; first_idx_i = 5'd0; ea_i = 64'hDEAD_0000;
                    end
                    if (k < int'(v.lat))
                        chk(!mem_req_o && !rf_we_o, "R6", "quiet while read outstanding",
                            {62'd0, mem_req_o, rf_we_o}, 64'd0);
                end
                mem_valid_i = 1'b1;
                mem_data_i  = mdata(exp_addr);
                #1;
                chk(rf_we_o, "R1", "write enable with data", {63'd0, rf_we_o}, 64'd1);
                chk(rf_idx_o == exp_idx, "R1", "write index", {59'd0, rf_idx_o}, {59'd0, exp_idx});
                chk(rf_data_o == {32'd0, mdata(exp_addr)}, "R2", "write data zero-extended",
                    rf_data_o, {32'd0, mdata(exp_addr)});
                chk(!mem_req_o, "R6", "no request in valid cycle", {63'd0, mem_req_o}, 64'd0);
                writes++;
                exp_addr = exp_addr + 64'd4;
                exp_idx  = exp_idx + 5'd1;
                @(negedge clk);
                mem_valid_i = 1'b0;
                start_i = 1'b0;
                first_idx_i = v.rt; ea_i = v.ea;
                if (writes < 32 - int'(v.rt))
                    chk(mem_req_o, "R6", "next request the cycle after valid", {63'd0, mem_req_o}, 64'd1);
            end else if (done_o) begin
                finished = 1'b1;
                chk(writes == 32 - int'(v.rt), "R1", "word count", 64'(writes), 64'(32 - int'(v.rt)));
                chk(exp_idx == 5'd0, "R7", "done follows register 31 write", {59'd0, exp_idx}, 64'd0);
                @(negedge clk);
                chk(!done_o && !mem_req_o, "R7", "done one cycle then idle",
                    {62'd0, done_o, mem_req_o}, 64'd0);
            end else begin
                chk(1'b0, "R1", "neither request nor done", 64'd0, 64'd1);
                finished = 1'b1;
            end
        end
        if (v.poke)
            chk(writes == 32 - int'(v.rt), "R8", "start during run ignored",
                64'(writes), 64'(32 - int'(v.rt)));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; first_idx_i = '0; base_idx_i = '0;
        ea_i = '0; le_mode_i = 1'b0; mem_valid_i = 1'b0; mem_data_i = '0;
        repeat (3) @(negedge clk);
        chk(!mem_req_o && !rf_we_o && !done_o && !inval_o && !align_o, "R9",
            "outputs low in reset", {59'd0, mem_req_o, rf_we_o, done_o, inval_o, align_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req_o && !rf_we_o && !done_o && !inval_o && !align_o, "R9",
            "outputs low after reset", {59'd0, mem_req_o, rf_we_o, done_o, inval_o, align_o}, 64'd0);

        for (int i = 0; i < NV; i++) run_op(VECS[i]);

        // R6: stray valid while idle writes nothing
        mem_valid_i = 1'b1; mem_data_i = 32'hFFFF_FFFF;
        #1;
        chk(!rf_we_o, "R6", "stray valid ignored", {63'd0, rf_we_o}, 64'd0);
        @(negedge clk);
        mem_valid_i = 1'b0;

        // R7: back-to-back start right after a completed run
        run_op(VECS[0]);
        run_op(VECS[0]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule